// File: doc/BRIEF.md
# Exception Entry Sequencer

This block steps a small CPU core into its exception handlers. It covers two cases. The first is leaving reset. The second is trapping an illegal instruction, which includes a PC-changing or multi-word instruction that sits in the slot right after a delayed branch. The core supplies the decoded class of the instruction it is issuing, a flag that says the previous instruction was a delayed branch, and the current PC, condition-code register and stack pointer. The sequencer then runs the memory traffic one access at a time over a request/acknowledge port.

When the reset pin is released, the block makes a single vector fetch and then loads the PC from that vector. It pushes no frame on reset. It raises the interrupt mask, NMI included, and keeps it raised until software clears it.

For an illegal instruction, the block writes the faulting PC and then the condition codes below the stack pointer. It then reads the matching vector and hands the core a new PC and the lowered stack pointer.

Top module: `exc_entry_seq`

## Requirements
- R1: While `rst_pin_n` is low, `mem_req` and `pc_load` stay 0, while `busy` and `irq_mask` stay 1.
- R2: After `rst_pin_n` rises, the block makes exactly one read at `VEC_BASE+0`. The cycle after that read is acknowledged, `pc_load` pulses with `pc_new` equal to the data read. `sp_load` stays 0 and no write is issued.
- R3: `irq_mask` stays 1 after the reset sequence ends. It clears only when `mask_clr` is 1 in a cycle where the block is idle. The next reset sets it again.
- R4: The general exception is raised when `ins_cls[0]` (undefined) is set and no slot exception applies. Its vector is read at `VEC_BASE+4`.
- R5: The slot exception is raised when `dly_slot` is 1 and any of `ins_cls[1]` (multi-word), `ins_cls[2]` (branch), `ins_cls[3]` (bit-conditional branch), `ins_cls[4]` (trap) or `ins_cls[5]` (return-from-exception) is set. Its vector is read at `VEC_BASE+8`. The same classes with `dly_slot` low raise nothing.
- R6: For either exception the block first writes to address SP-4, then writes the zero-extended CCR to SP-8, then reads the vector. At the load, `sp_load` pulses with `sp_new` equal to SP-8.
- R7: The PC that is pushed is the `fault_pc` value presented in the detection cycle. This lets the core report the word at which the fault was seen.
- R8: When the slot and general conditions hold together, the slot exception wins.
- R9: Pulling `rst_pin_n` low in the middle of a sequence aborts it. The next cycle shows the R1 state, and release runs the R2 sequence.
- R10: A request holds `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` steady until `mem_ack`. `busy` rises the cycle after detection and falls in the same cycle that `pc_load` pulses.
- R11: `issue_valid` is ignored while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_pin_n | input | 1 | active-low reset pin, sampled on the clock |
| issue_valid | input | 1 | an instruction is being issued this cycle |
| ins_cls | input | 6 | decoded class bits: 0 undefined, 1 multi-word, 2 branch, 3 bit-cond branch, 4 trap, 5 return |
| dly_slot | input | 1 | the issued instruction follows a delayed branch |
| fault_pc | input | AW | PC value to save if this instruction traps |
| cur_ccr | input | CW | current condition codes |
| cur_sp | input | AW | current stack pointer (register 7) |
| mask_clr | input | 1 | software request to unmask interrupts |
| mem_req | output | 1 | memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | AW | byte address |
| mem_wdata | output | DW | write data |
| mem_ack | input | 1 | access complete |
| mem_rdata | input | DW | read data, valid with ack |
| busy | output | 1 | sequence in progress |
| pc_load | output | 1 | one-cycle strobe: load pc_new |
| pc_new | output | AW | handler or start address |
| sp_load | output | 1 | one-cycle strobe: load sp_new |
| sp_new | output | AW | stack pointer after the push |
| irq_mask | output | 1 | all interrupts, NMI included, masked |

## Verification
Every result of this block appears one clock edge after its cause. For a trap, `busy` and the first push request show up on the edge after the issue cycle. Each further request follows on the edge that samples the previous acknowledge. `pc_load`, `sp_load` and the fall of `busy` come on the edge after the vector acknowledge. The bench drives inputs and samples outputs on the falling clock edge. It inspects each result at the first falling edge after the rising edge that should produce it, and it stretches acknowledges by zero to two cycles to confirm that requests stay stable while they wait.

// File: rtl/exc_pkg.sv
`timescale 1ns/1ps
package exc_pkg;
  typedef enum logic [2:0] {
    ST_RST  = 3'd0,
    ST_RVEC = 3'd1,
    ST_IDLE = 3'd2,
    ST_PPC  = 3'd3,
    ST_PCCR = 3'd4,
    ST_GVEC = 3'd5
  } seq_st_t;

  typedef enum logic [1:0] {
    EXC_NONE = 2'd0,
    EXC_GEN  = 2'd1,
    EXC_SLOT = 2'd2
  } exc_kind_t;

  localparam int unsigned NCLS = 6;
  // bit 0 undefined; bits 1..5 are the classes forbidden in a delay slot
  localparam logic [NCLS-1:0] SLOT_BAD = 6'b111110;
endpackage

// File: rtl/exc_classify.sv
`timescale 1ns/1ps
module exc_classify
  import exc_pkg::*;
(
  input  logic [NCLS-1:0] cls,
  input  logic            dly,
  output exc_kind_t       kind
);
  logic [NCLS-1:0] slot_hit;

  for (genvar g = 0; g < NCLS; g++) begin : g_slot
    assign slot_hit[g] = dly & cls[g] & SLOT_BAD[g];
  end

  always_comb begin
    if (|slot_hit)   kind = EXC_SLOT;
    else if (cls[0]) kind = EXC_GEN;
    else             kind = EXC_NONE;
  end
endmodule

// File: rtl/exc_addr_gen.sv
`timescale 1ns/1ps
module exc_addr_gen
  import exc_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32,
  parameter int unsigned CW = 8,
  parameter logic [31:0] VEC_BASE = 32'h0
) (
  input  seq_st_t         st,
  input  logic [AW-1:0]   sp_q,
  input  logic [AW-1:0]   pc_q,
  input  logic [CW-1:0]   ccr_q,
  input  logic            slot_q,
  output logic            req,
  output logic            we,
  output logic [AW-1:0]   addr,
  output logic [DW-1:0]   wdata
);
  localparam int unsigned   WORD_B = DW / 8;
  localparam logic [AW-1:0] STEP   = AW'(WORD_B);
  localparam logic [AW-1:0] BASE   = AW'(VEC_BASE);

  always_comb begin
    req   = 1'b0;
    we    = 1'b0;
    addr  = '0;
    wdata = '0;
    unique case (st)
      ST_RVEC: begin
        req  = 1'b1;
        addr = BASE;
      end
      ST_PPC: begin
        req   = 1'b1;
        we    = 1'b1;
        addr  = sp_q - STEP;
        wdata = DW'(pc_q);
      end
      ST_PCCR: begin
        req   = 1'b1;
        we    = 1'b1;
        addr  = sp_q - (STEP << 1);
        wdata = {{(DW-CW){1'b0}}, ccr_q};
      end
      ST_GVEC: begin
        req  = 1'b1;
        addr = slot_q ? BASE + (STEP << 1) : BASE + STEP;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/exc_entry_seq.sv
`timescale 1ns/1ps
module exc_entry_seq
  import exc_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32,
  parameter int unsigned CW = 8,
  parameter logic [31:0] VEC_BASE = 32'h0
) (
  input  logic            clk,
  input  logic            rst_pin_n,
  input  logic            issue_valid,
  input  logic [5:0]      ins_cls,
  input  logic            dly_slot,
  input  logic [AW-1:0]   fault_pc,
  input  logic [CW-1:0]   cur_ccr,
  input  logic [AW-1:0]   cur_sp,
  input  logic            mask_clr,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic            mem_ack,
  input  logic [DW-1:0]   mem_rdata,
  output logic            busy,
  output logic            pc_load,
  output logic [AW-1:0]   pc_new,
  output logic            sp_load,
  output logic [AW-1:0]   sp_new,
  output logic            irq_mask
);
  localparam logic [AW-1:0] FRAME = AW'(2 * (DW / 8));

  seq_st_t       st;
  exc_kind_t     kind;
  logic [AW-1:0] sp_q, pc_q;
  logic [CW-1:0] ccr_q;
  logic          slot_q;

  exc_classify u_cls (
    .cls  (ins_cls),
    .dly  (dly_slot),
    .kind (kind)
  );

  exc_addr_gen #(.AW(AW), .DW(DW), .CW(CW), .VEC_BASE(VEC_BASE)) u_agen (
    .st     (st),
    .sp_q   (sp_q),
    .pc_q   (pc_q),
    .ccr_q  (ccr_q),
    .slot_q (slot_q),
    .req    (mem_req),
    .we     (mem_we),
    .addr   (mem_addr),
    .wdata  (mem_wdata)
  );

  assign busy = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_pin_n) begin
      st       <= ST_RST;
      irq_mask <= 1'b1;
      pc_load  <= 1'b0;
      sp_load  <= 1'b0;
      pc_new   <= '0;
      sp_new   <= '0;
      sp_q     <= '0;
      pc_q     <= '0;
      ccr_q    <= '0;
      slot_q   <= 1'b0;
    end else begin
      pc_load <= 1'b0;
      sp_load <= 1'b0;
      if (mask_clr && st == ST_IDLE) irq_mask <= 1'b0;
      unique case (st)
        ST_RST: st <= ST_RVEC;
        ST_RVEC: if (mem_ack) begin
          pc_new  <= AW'(mem_rdata);
          pc_load <= 1'b1;
          st      <= ST_IDLE;
        end
        ST_IDLE: if (issue_valid && kind != EXC_NONE) begin
          sp_q   <= cur_sp;
          pc_q   <= fault_pc;
          ccr_q  <= cur_ccr;
          slot_q <= (kind == EXC_SLOT);
          st     <= ST_PPC;
        end
        ST_PPC:  if (mem_ack) st <= ST_PCCR;
        ST_PCCR: if (mem_ack) st <= ST_GVEC;
        ST_GVEC: if (mem_ack) begin
          pc_new  <= AW'(mem_rdata);
          pc_load <= 1'b1;
          sp_new  <= sp_q - FRAME;
          sp_load <= 1'b1;
          st      <= ST_IDLE;
        end
        default: st <= ST_RST;
      endcase
    end
  end
endmodule

// File: rtl/exc_entry_chk.sv
`timescale 1ns/1ps
module exc_entry_chk #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst_pin_n,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_ack,
  input logic          busy,
  input logic          pc_load,
  input logic          sp_load,
  input logic          irq_mask,
  input logic          mask_clr
);
  logic was_low;
  always_ff @(posedge clk) was_low <= !rst_pin_n;

  always @(negedge clk) begin
    if (was_low === 1'b1) begin
      // R1
      reset_hold_chk: assert (!mem_req && !pc_load && busy && irq_mask)
        else $error("reset state violated");
    end
  end

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R3
  mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
    (irq_mask && !mask_clr) |=> irq_mask);

  // R10
  load_idle_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
    pc_load |-> !busy);

  // R6
  sp_with_pc_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
    sp_load |-> pc_load);

  // R10
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
    $fell(busy) |-> pc_load);
endmodule

bind exc_entry_seq exc_entry_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_pin_n (rst_pin_n),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_ack   (mem_ack),
  .busy      (busy),
  .pc_load   (pc_load),
  .sp_load   (sp_load),
  .irq_mask  (irq_mask),
  .mask_clr  (mask_clr)
);

// File: tb/exc_entry_seq_tb.sv
`timescale 1ns/1ps
module exc_entry_seq_tb_top;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int CW = 8;
  localparam int NV = 9;
  // entry: {ins_cls[5:0], dly, kind[1:0]}; kind 0 none, 1 general, 2 slot
  localparam logic [8:0] VECS [NV] = '{
    {6'b000001, 1'b0, 2'd1},
    {6'b000001, 1'b1, 2'd1},
    {6'b000010, 1'b1, 2'd2},
    {6'b000100, 1'b1, 2'd2},
    {6'b001000, 1'b1, 2'd2},
    {6'b010000, 1'b1, 2'd2},
    {6'b100000, 1'b1, 2'd2},
    {6'b111110, 1'b0, 2'd0},
    {6'b010001, 1'b1, 2'd2}
  };

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_pin_n = 1'b0, issue_valid = 1'b0, dly_slot = 1'b0, mask_clr = 1'b0;
  logic [5:0] ins_cls = '0;
  logic [AW-1:0] fault_pc = '0, cur_sp = '0;
  logic [CW-1:0] cur_ccr = '0;
  logic mem_ack = 1'b0;
  logic [DW-1:0] mem_rdata = '0;
  logic mem_req, mem_we, busy, pc_load, sp_load, irq_mask;
  logic [AW-1:0] mem_addr, pc_new, sp_new;
  logic [DW-1:0] mem_wdata;

  exc_entry_seq dut_i (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic serve(input logic [31:0] ea, input logic ewe, input logic [31:0] ed,
                       input logic [31:0] rd, input int lat, input string tag);
    chk({tag, " req"}, mem_req, 1);
    chk({tag, " addr"}, mem_addr, ea);
    chk({tag, " we"}, mem_we, ewe);
    if (ewe) chk({tag, " wdata"}, mem_wdata, ed);
    for (int k = 0; k < lat; k++) begin
      @(negedge clk);
      chk({"R10 hold ", tag}, {mem_req, mem_addr}, {1'b1, ea});
    end
    mem_ack = 1'b1;
    mem_rdata = rd;
    @(negedge clk);
    mem_ack = 1'b0;
  endtask

  task automatic do_reset(input logic [31:0] start);
    rst_pin_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 req", mem_req, 0);
    chk("R1 busy", busy, 1);
    chk("R1 mask", irq_mask, 1);
    chk("R1 pc_load", pc_load, 0);
    rst_pin_n = 1'b1;
    @(negedge clk);
    serve(32'h0, 1'b0, 32'h0, start, 1, "R2 rvec");
    chk("R2 pc_load", pc_load, 1);
    chk("R2 pc_new", pc_new, start);
    chk("R2 sp_load", sp_load, 0);
    chk("R2 busy", busy, 0);
    chk("R3 mask after reset", irq_mask, 1);
    @(negedge clk);
    chk("R2 no further req", mem_req, 0);
  endtask

  task automatic issue(input logic [5:0] c, input logic d, input logic [31:0] pc,
                       input logic [31:0] sp, input logic [7:0] ccr);
    ins_cls = c; dly_slot = d; fault_pc = pc; cur_sp = sp; cur_ccr = ccr;
    issue_valid = 1'b1;
    @(negedge clk);
    issue_valid = 1'b0; ins_cls = '0; dly_slot = 1'b0;
  endtask

  task automatic finish_seq(input logic [31:0] pc, input logic [31:0] sp, input logic [7:0] ccr,
                            input logic slot, input logic [31:0] hv, input int lat);
    serve(sp - 4, 1'b1, pc, 32'h0, lat, "R6 R7 push pc");
    serve(sp - 8, 1'b1, {24'h0, ccr}, 32'h0, lat, "R6 push ccr");
    serve(slot ? 32'h8 : 32'h4, 1'b0, 32'h0, hv, lat, slot ? "R5 slot vec" : "R4 gen vec");
    chk("R10 pc_load", pc_load, 1);
    chk("R6 pc_new", pc_new, hv);
    chk("R6 sp_load", sp_load, 1);
    chk("R6 sp_new", sp_new, sp - 8);
    chk("R10 busy low at load", busy, 0);
  endtask

  initial begin
    #(5ns * 20000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog act=running exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset(32'h1000);

    // table walk: R4 R5 R8
    for (int i = 0; i < NV; i++) begin
      logic [31:0] pc, sp, hv;
      logic [7:0] ccr;
      pc = 32'h2000 + i * 6;
      sp = 32'h8000 - i * 16;
      ccr = 8'h80 | 8'(i);
      hv = 32'h4000 + i * 32'h100;
      issue(VECS[i][8:3], VECS[i][2], pc, sp, ccr);
      if (VECS[i][1:0] == 2'd0) begin
        chk("R5 legal outside slot busy", busy, 0);
        chk("R5 legal outside slot req", mem_req, 0);
      end else begin
        chk("R10 busy after detect", busy, 1);
        finish_seq(pc, sp, ccr, VECS[i][1:0] == 2'd2, hv, i % 3);
      end
      @(negedge clk);
      chk("R10 pc_load one cycle", pc_load, 0);
    end

    // R11: issue while busy is ignored
    issue(6'b000001, 1'b0, 32'h3000, 32'h9000, 8'h5A);
    ins_cls = 6'b010001; dly_slot = 1'b1; fault_pc = 32'h3333; cur_sp = 32'h7777;
    issue_valid = 1'b1;
    @(negedge clk);
    issue_valid = 1'b0; ins_cls = '0; dly_slot = 1'b0;
    finish_seq(32'h3000, 32'h9000, 8'h5A, 1'b0, 32'h5000, 0);
    @(negedge clk);
    chk("R11 no second sequence", busy, 0);

    // R3: mask clear while idle, then reset sets it again
    mask_clr = 1'b1;
    @(negedge clk);
    mask_clr = 1'b0;
    chk("R3 mask cleared", irq_mask, 0);

    // R9: reset during the ccr push aborts
    issue(6'b000001, 1'b0, 32'h3100, 32'h9100, 8'h11);
    serve(32'h90FC, 1'b1, 32'h3100, 32'h0, 0, "R9 first push");
    rst_pin_n = 1'b0;
    @(negedge clk);
    chk("R9 req dropped", mem_req, 0);
    chk("R9 mask set", irq_mask, 1);
    chk("R9 busy", busy, 1);
    do_reset(32'h1200);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule